// File: doc/BRIEF.md
# Power-Mode and Clock-Source Controller

This block sets the operating mode of a small processor core. Software writes an eight-bit control register. Bit 7 is the idle-enable bit. Bits 1:0 form the clock-source field, which picks one of three sources: the primary source, a low-frequency secondary source, or an internal RC source. Each source reports a ready flag. The block drives a clock-source select and two clock enables, one for the CPU clock and one for the peripheral clock. Downstream gating and multiplexing cells use these outputs.

There are seven modes. The three run modes clock both the CPU and the peripherals. The three idle modes clock only the peripherals. Sleep stops every clock. The clock-source field does two jobs. While the CPU runs, it chooses the source. When the sleep-instruction strobe arrives, the idle-enable bit sampled at that moment decides the target: idle on that source, or full sleep. A source change takes effect only once the new source reports ready. Until then the old source stays selected and a pending flag is raised.

The controller FSM has four states: RUN, IDLE, SLEEP and WAKE.
- RUN moves to IDLE (sleep strobe, idle-enable 1) or to SLEEP (sleep strobe, idle-enable 0).
- IDLE moves to RUN on a wake event.
- SLEEP moves to WAKE on a wake event.
- WAKE waits for the target source to be ready, then loads that source and moves to RUN.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in primary run: mode code 0, select 00, both enables 1, pending 0, and the register reads 0x00.
- R2: The source field is decoded as follows: 00 selects primary (select 00), 01 selects secondary (select 01), and 10 or 11 selects internal (select 10). When the new source is ready, the select moves on the clock edge after the write edge.
- R3: If the chosen source is not ready, the select keeps the old source and pending stays 1 until that source's ready flag rises.
- R4: A sleep strobe in RUN with idle-enable 1 enters idle on the edge of the strobe. The CPU enable goes to 0, and the peripheral enable stays 1 on the selected source.
- R5: A sleep strobe in RUN with idle-enable 0 enters sleep. Both enables go to 0 and the select shows 11 (no source).
- R6: Writes to idle-enable made after the strobe do not change the idle or sleep mode already entered.
- R7: A wake event in IDLE returns to the matching run mode on the next edge.
- R8: A wake event in SLEEP moves to a wake-wait phase that still reports sleep. The block returns to run on the source named by the current field, but only after that source is ready. This takes at least two edges.
- R9: A sleep strobe outside RUN is ignored, and a wake event in RUN is ignored. When a sleep strobe and a wake event arrive together in RUN, the sleep strobe wins.
- R10: Pending equals 1 exactly while the block is awake and the field names a source other than the selected one. Pending clears in the same cycle that the select moves, and it is 0 in sleep.
- R11: The mode code is 0, 1 or 2 for primary, secondary or internal run; 3, 4 or 5 for the matching idle modes; and 6 for sleep, including the wake wait.
- R12: The register reads back the last value written, all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_wdata | input | 8 | Write data (bit 7 idle-enable, bits 1:0 source field) |
| cfg_rdata | output | 8 | Control-register readback |
| sleep_req | input | 1 | Sleep-instruction strobe |
| wake_evt | input | 1 | Wake event |
| rdy_pri | input | 1 | Primary source running |
| rdy_sec | input | 1 | Secondary source running |
| rdy_int | input | 1 | Internal RC source running |
| clk_sel | output | 2 | Selected source: 00 primary, 01 secondary, 10 internal, 11 none |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| switch_pending | output | 1 | Source change waiting for ready |
| mode_code | output | 3 | Current mode code |

## Verification
The bench holds a source's ready flag low across several cycles after a switch request. A design that switched regardless would move the select early and drop pending. It then clears idle-enable while the block idles: a design that re-read the bit instead of latching it at the strobe would fall into sleep. The bench also wakes from sleep while the target source is not ready. A design that skipped the wait would turn the clocks back on at once. It also sleeps with a switch still pending, and a design that reloaded the old source on wake would come back on the wrong clock. Finally, it sends sleep and wake strobes in states where they must be ignored, and sends both together in RUN. A design that mishandled either would change mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_W   = $clog2(NUM_SRC + 1);
    localparam int MODE_W  = 3;

    localparam logic [SRC_W-1:0] SRC_PRI  = 2'd0;
    localparam logic [SRC_W-1:0] SRC_SEC  = 2'd1;
    localparam logic [SRC_W-1:0] SRC_INT  = 2'd2;
    localparam logic [SRC_W-1:0] SRC_NONE = 2'd3;

    localparam logic [MODE_W-1:0] MODE_IDLE_BASE = 3'd3;
    localparam logic [MODE_W-1:0] MODE_SLEEP     = 3'd6;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } pm_state_e;

    function automatic logic [SRC_W-1:0] decode_field(input logic [1:0] f);
        if (f[1])      return SRC_INT;
        else if (f[0]) return SRC_SEC;
        else           return SRC_PRI;
    endfunction
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg #(
    parameter int CTRL_W   = 8,
    parameter int IDLE_BIT = 7,
    parameter int SEL_LSB  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic              idle_en,
    output logic [1:0]        sel_field
);
    logic [CTRL_W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  reg_q <= '0;
        else if (wr) reg_q <= wdata;
    end

    assign rdata     = reg_q;
    assign idle_en   = reg_q[IDLE_BIT];
    assign sel_field = reg_q[SEL_LSB +: 2];

    p_readback_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == $past(wdata)));
endmodule

// File: rtl/pmc_src_track.sv
module pmc_src_track
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   tgt_src,
    input  logic [NUM_SRC-1:0] rdy,
    input  logic               awake,
    input  logic               force_load,
    output logic [SRC_W-1:0]   cur_src,
    output logic               tgt_rdy
);
    always_comb begin
        tgt_rdy = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (tgt_src == SRC_W'(i)) tgt_rdy = rdy[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_src <= SRC_PRI;
        else if (force_load || (awake && tgt_src != cur_src && tgt_rdy))
            cur_src <= tgt_src;
    end

    p_hold_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !force_load && tgt_src != cur_src && !tgt_rdy) |=> (cur_src == $past(cur_src)));

    p_never_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src != SRC_NONE);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic              idle_en,
    input  logic              tgt_rdy,
    input  logic [SRC_W-1:0]  tgt_src,
    input  logic [SRC_W-1:0]  cur_src,
    output logic              awake,
    output logic              wake_done,
    output logic [SRC_W-1:0]  clk_sel,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              switch_pending,
    output logic [MODE_W-1:0] mode_code
);
    pm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep_req) state_d = idle_en ? ST_IDLE : ST_SLEEP;
            ST_IDLE:  if (wake_evt)  state_d = ST_RUN;
            ST_SLEEP: if (wake_evt)  state_d = ST_WAKE;
            ST_WAKE:  if (tgt_rdy)   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        awake          = 1'b0;
        wake_done      = 1'b0;
        clk_sel        = SRC_NONE;
        cpu_clk_en     = 1'b0;
        per_clk_en     = 1'b0;
        mode_code      = MODE_SLEEP;
        unique case (state_q)
            ST_RUN: begin
                awake      = 1'b1;
                clk_sel    = cur_src;
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
                mode_code  = MODE_W'(cur_src);
            end
            ST_IDLE: begin
                awake      = 1'b1;
                clk_sel    = cur_src;
                per_clk_en = 1'b1;
                mode_code  = MODE_IDLE_BASE + MODE_W'(cur_src);
            end
            ST_SLEEP: begin
            end
            ST_WAKE: begin
                wake_done = tgt_rdy;
            end
        endcase
        switch_pending = awake && (tgt_src != cur_src);
    end

    p_idle_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && idle_en) |=> (state_q == ST_IDLE));
    p_sleep_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && !idle_en) |=> (state_q == ST_SLEEP));
    p_idle_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wake_evt) |=> (state_q == ST_IDLE));
    p_idle_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wake_evt) |=> (state_q == ST_RUN));
    p_wake_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !tgt_rdy) |=> (state_q == ST_WAKE && !per_clk_en));
    p_sel_move_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel) && clk_sel != SRC_NONE && $past(clk_sel) != SRC_NONE)
            |-> !switch_pending);
    p_sleep_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == MODE_SLEEP) |-> (!cpu_clk_en && !per_clk_en && clk_sel == SRC_NONE));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int IDLE_BIT = 7,
    parameter int SEL_LSB  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              sleep_req,
    input  logic              wake_evt,
    input  logic              rdy_pri,
    input  logic              rdy_sec,
    input  logic              rdy_int,
    output logic [1:0]        clk_sel,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              switch_pending,
    output logic [2:0]        mode_code
);
    logic             idle_en;
    logic [1:0]       sel_field;
    logic [SRC_W-1:0] tgt_src;
    logic [SRC_W-1:0] cur_src;
    logic             tgt_rdy;
    logic             awake;
    logic             wake_done;

    pmc_ctrl_reg #(
        .CTRL_W   (CTRL_W),
        .IDLE_BIT (IDLE_BIT),
        .SEL_LSB  (SEL_LSB)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .idle_en   (idle_en),
        .sel_field (sel_field)
    );

    assign tgt_src = decode_field(sel_field);

    pmc_src_track u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgt_src    (tgt_src),
        .rdy        ({rdy_int, rdy_sec, rdy_pri}),
        .awake      (awake),
        .force_load (wake_done),
        .cur_src    (cur_src),
        .tgt_rdy    (tgt_rdy)
    );

    pmc_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_req      (sleep_req),
        .wake_evt       (wake_evt),
        .idle_en        (idle_en),
        .tgt_rdy        (tgt_rdy),
        .tgt_src        (tgt_src),
        .cur_src        (cur_src),
        .awake          (awake),
        .wake_done      (wake_done),
        .clk_sel        (clk_sel),
        .cpu_clk_en     (cpu_clk_en),
        .per_clk_en     (per_clk_en),
        .switch_pending (switch_pending),
        .mode_code      (mode_code)
    );
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       rdy_pri = 1'b1;
    logic       rdy_sec = 1'b1;
    logic       rdy_int = 1'b1;
    logic [1:0] clk_sel;
    logic       cpu_clk_en, per_clk_en, switch_pending;
    logic [2:0] mode_code;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_reg = 8'h00;

    typedef struct {
        logic [2:0] mode;
        logic       pend;
        logic [7:0] rd;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .rdy_pri(rdy_pri), .rdy_sec(rdy_sec), .rdy_int(rdy_int),
        .clk_sel(clk_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .switch_pending(switch_pending), .mode_code(mode_code)
    );

    function automatic logic [5:0] outs_for(input logic [2:0] m, input logic p, input logic [7:0] r);
        logic [1:0] s;
        logic c, q;
        if (m < 3'd3)      begin s = m[1:0];        c = 1'b1; q = 1'b1; end
        else if (m < 3'd6) begin s = 2'(m - 3'd3);  c = 1'b0; q = 1'b1; end
        else               begin s = 2'b11;         c = 1'b0; q = 1'b0; end
        return {s, c, q, p, ^r};
    endfunction

    task automatic compare(input exp_t e);
        logic [5:0] want, got;
        want = outs_for(e.mode, e.pend, e.rd);
        got  = {clk_sel, cpu_clk_en, per_clk_en, switch_pending, ^cfg_rdata};
        checks++;
        if (mode_code !== e.mode || got !== want || cfg_rdata !== e.rd) begin
            fails++;
            $display("FAIL %s: got mode=%0d sel=%b cpu=%b per=%b pend=%b rd=%h, expected mode=%0d sel=%b cpu=%b per=%b pend=%b rd=%h",
                     e.tag, mode_code, clk_sel, cpu_clk_en, per_clk_en, switch_pending, cfg_rdata,
                     e.mode, want[5:4], want[3], want[2], want[1], e.rd);
        end
    endtask

    // monitor: pops one expected item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    // driver: applies one cycle of stimulus and queues the outcome after the next edge
    task automatic drive(input logic wr, input logic [7:0] d, input logic slp, input logic wk,
                         input logic [2:0] rdy, input logic [2:0] m, input logic p, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_wr    = wr;
        cfg_wdata = d;
        sleep_req = slp;
        wake_evt  = wk;
        {rdy_int, rdy_sec, rdy_pri} = rdy;
        if (wr) exp_reg = d;
        e.mode = m; e.pend = p; e.rd = exp_reg; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        exp_t r;
        #23;
        r.mode = 3'd0; r.pend = 1'b0; r.rd = 8'h00; r.tag = "R1 reset";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 / R10 source switching
        drive(1, 8'h01, 0, 0, 3'b111, 3'd0, 1, "R10 pending one cycle");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd1, 0, "R2 secondary");
        drive(1, 8'h02, 0, 0, 3'b111, 3'd1, 1, "R10 pending");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd2, 0, "R2 internal 10");
        drive(1, 8'h03, 0, 0, 3'b111, 3'd2, 0, "R2 internal 11");
        // R3 wait for primary
        drive(1, 8'h00, 0, 0, 3'b110, 3'd2, 1, "R3 unready");
        drive(0, 8'h00, 0, 0, 3'b110, 3'd2, 1, "R3 hold");
        drive(0, 8'h00, 0, 0, 3'b110, 3'd2, 1, "R3 hold");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd0, 0, "R10 move clears");
        // idle path
        drive(1, 8'h81, 0, 0, 3'b111, 3'd0, 1, "R12 readback");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd1, 0, "R2 secondary");
        drive(0, 8'h00, 1, 0, 3'b111, 3'd4, 0, "R4 idle entry");
        drive(1, 8'h01, 0, 0, 3'b111, 3'd4, 0, "R6 late write");
        drive(0, 8'h00, 1, 0, 3'b111, 3'd4, 0, "R9 strobe in idle");
        drive(0, 8'h00, 0, 1, 3'b111, 3'd1, 0, "R7 wake idle");
        drive(0, 8'h00, 0, 1, 3'b111, 3'd1, 0, "R9 wake in run");
        // sleep path
        drive(0, 8'h00, 1, 0, 3'b111, 3'd6, 0, "R5 sleep entry");
        drive(0, 8'h00, 0, 1, 3'b101, 3'd6, 0, "R8 wake wait");
        drive(0, 8'h00, 0, 0, 3'b101, 3'd6, 0, "R8 wake wait");
        drive(0, 8'h00, 1, 0, 3'b101, 3'd6, 0, "R9 strobe in sleep");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd1, 0, "R8 ready resume");
        // mode table
        drive(1, 8'h82, 0, 0, 3'b111, 3'd1, 1, "R10 pending");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd2, 0, "R11 int run");
        drive(0, 8'h00, 1, 0, 3'b111, 3'd5, 0, "R11 int idle");
        drive(0, 8'h00, 0, 1, 3'b111, 3'd2, 0, "R7 wake idle");
        drive(1, 8'h80, 0, 0, 3'b111, 3'd2, 1, "R12 readback");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd0, 0, "R11 pri run");
        drive(0, 8'h00, 1, 0, 3'b111, 3'd3, 0, "R11 pri idle");
        drive(0, 8'h00, 0, 1, 3'b111, 3'd0, 0, "R7 wake idle");
        // sleep with a pending switch, then wake onto the new source
        drive(1, 8'h02, 0, 0, 3'b011, 3'd0, 1, "R3 unready");
        drive(0, 8'h00, 1, 0, 3'b011, 3'd6, 0, "R5 sleep entry");
        drive(0, 8'h00, 0, 1, 3'b111, 3'd6, 0, "R8 two edges");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd2, 0, "R8 new source");
        // simultaneous strobes in run
        drive(0, 8'h00, 1, 1, 3'b111, 3'd6, 0, "R9 sleep wins");
        drive(0, 8'h00, 0, 1, 3'b111, 3'd6, 0, "R8 wake wait");
        drive(0, 8'h00, 0, 0, 3'b111, 3'd2, 0, "R8 resume");
        @(negedge clk);
        sleep_req = 1'b0;
        wake_evt  = 1'b0;
        cfg_wr    = 1'b0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule